// File: doc/BRIEF.md
# Pre-Adder Multiplier Input Stage

This block is the operand front end of a multiply-accumulate datapath. A 30-bit A operand and an 18-bit B operand each pass through two cascaded registers, and every register has its own load enable. A 25-bit D operand is captured in its own register. A 25-bit pre-adder combines D with the low 25 bits of a chosen A register. A signed 25×18 multiplier takes that result and one of the two B registers, and a product register with its own enable holds the 43-bit signed product.

A 5-bit mode word is applied every clock and acts on the register contents at that same edge. It chooses which A level and which B level feed the arithmetic. It can force the A term or the D term to zero, and it chooses between D + A and D − A. Because each register loads only when its enable is high, one level can hold a value for reuse while the other takes in new data. Sequential complex or wide multiplies use this to read each operand from memory once.

Separate cascade outputs carry the A and B operands onward to a neighbouring stage or to a downstream ALU. Their register depth (0, 1 or 2) is a build-time parameter for each operand and does not depend on the mode word.

Top module: `preadd_mult_stage`

## Requirements
- R1: A synchronous active-high `rst` clears every register. At the first falling edge after a reset edge, `prod_out`, `acas_out` (depth 1) and `bcas_out` (depth 2) are zero.
- R2: The first A register loads `a_in` at an edge where `ce_a1` is 1 and otherwise holds. The second A register loads the first at an edge where `ce_a2` is 1 and otherwise holds. The B registers behave the same way with `ce_b1` and `ce_b2`.
- R3: Mode bit 0 chooses the A source: 1 selects the first A register and 0 selects the second.
- R4: Mode bit 4 chooses the B source: 1 selects the first B register and 0 selects the second.
- R5: When mode bit 1 is 1, the A term of the pre-adder is zero.
- R6: When mode bit 2 is 0, the D term of the pre-adder is zero; when it is 1, the D register is used.
- R7: Mode bit 3 set computes D − A, and clear computes D + A. The result is 25 bits and wraps modulo 2^25 before it is used as a signed multiplicand.
- R8: Only bits 24:0 of the selected A register reach the pre-adder; bits 29:25 have no effect on the product.
- R9: At an edge where `ce_m` is 1, the product register loads the signed product of the pre-adder result and the selected B register, using the register contents and `mode` present at that edge. At an edge where `ce_m` is 0, `prod_out` holds.
- R10: `acas_out` shows `a_in` when `CAS_A_DEPTH` is 0, the first A register when it is 1, and the second when it is 2. `bcas_out` follows `CAS_B_DEPTH` in the same way. `mode` has no effect on either output.
- R11: The D register loads `d_in` at an edge where `ce_d` is 1 and otherwise holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | A_W (30) | A operand input |
| b_in | input | B_W (18) | B operand input |
| d_in | input | D_W (25) | D operand input |
| ce_a1 | input | 1 | Load enable, first A register |
| ce_a2 | input | 1 | Load enable, second A register |
| ce_b1 | input | 1 | Load enable, first B register |
| ce_b2 | input | 1 | Load enable, second B register |
| ce_d | input | 1 | Load enable, D register |
| ce_m | input | 1 | Load enable, product register |
| mode | input | 5 | Per-cycle operand and pre-adder control |
| prod_out | output | D_W+B_W (43) | Registered signed product |
| acas_out | output | A_W (30) | A cascade output at the static depth |
| bcas_out | output | B_W (18) | B cascade output at the static depth |

## Verification
Every internal register reaches the ports within one edge. A wrong A or B register value shows on `prod_out` at the first `ce_m` edge whose mode selects that level, and shows at once on a cascade output tapped at that depth. A wrong D register value shows at the next `ce_m` edge that enables D. A fault in the pre-adder or in the mode decode corrupts the product captured at the very edge where that mode is applied. To make such faults visible, the bench loads the two levels of each operand with different values, so a wrong level choice gives a different product.

// File: rtl/dsp_in_pkg.sv
package dsp_in_pkg;

  // Per-cycle control word, MSB first: bit4 .. bit0
  typedef struct packed {
    logic b_first;   // bit 4: 1 -> first B register, 0 -> second
    logic subtract;  // bit 3: 1 -> D - A, 0 -> D + A
    logic d_enable;  // bit 2: 1 -> D register used, 0 -> zero
    logic a_zero;    // bit 1: 1 -> A term forced to zero
    logic a_first;   // bit 0: 1 -> first A register, 0 -> second
  } mode_t;

endpackage

// File: rtl/twin_reg_path.sv
module twin_reg_path #(
  parameter int W         = 30,
  parameter int CAS_DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         ce1,
  input  logic         ce2,
  output logic [W-1:0] q1,
  output logic [W-1:0] q2,
  output logic [W-1:0] cas_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q1 <= '0;
      q2 <= '0;
    end else begin
      if (ce1) q1 <= din;
      if (ce2) q2 <= q1;
    end
  end

  // Static tap for the cascade / ALU route
  generate
    if (CAS_DEPTH == 0) begin : g_tap0
      assign cas_out = din;
    end else if (CAS_DEPTH == 1) begin : g_tap1
      assign cas_out = q1;
    end else begin : g_tap2
      assign cas_out = q2;
    end
  endgenerate

endmodule

// File: rtl/preadd_unit.sv
module preadd_unit
  import dsp_in_pkg::*;
#(
  parameter int D_W = 25
) (
  input  logic [D_W-1:0] a_lvl1,
  input  logic [D_W-1:0] a_lvl2,
  input  logic [D_W-1:0] d_val,
  input  mode_t          md,
  output logic [D_W-1:0] a_term,
  output logic [D_W-1:0] d_term,
  output logic [D_W-1:0] pre_sum
);

  function automatic logic [D_W-1:0] combine(input logic [D_W-1:0] dv,
                                             input logic [D_W-1:0] av,
                                             input logic           sub);
    return sub ? (dv - av) : (dv + av);
  endfunction

  always_comb begin
    a_term  = md.a_zero ? '0 : (md.a_first ? a_lvl1 : a_lvl2);
    d_term  = md.d_enable ? d_val : '0;
    pre_sum = combine(d_term, a_term, md.subtract);
  end

endmodule

// File: rtl/mult_stage.sv
module mult_stage #(
  parameter int D_W = 25,
  parameter int B_W = 18,
  localparam int P_W = D_W + B_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ce_m,
  input  logic [D_W-1:0] mcand,
  input  logic [B_W-1:0] b_lvl1,
  input  logic [B_W-1:0] b_lvl2,
  input  logic           b_first,
  output logic [B_W-1:0] mplier,
  output logic [P_W-1:0] m_q
);

  function automatic logic [P_W-1:0] smul(input logic [D_W-1:0] x,
                                          input logic [B_W-1:0] y);
    logic signed [P_W-1:0] xs;
    logic signed [P_W-1:0] ys;
    xs = P_W'($signed(x));
    ys = P_W'($signed(y));
    return xs * ys;
  endfunction

  assign mplier = b_first ? b_lvl1 : b_lvl2;

  always_ff @(posedge clk) begin
    if (rst)       m_q <= '0;
    else if (ce_m) m_q <= smul(mcand, mplier);
  end

endmodule

// File: rtl/preadd_mult_stage.sv
module preadd_mult_stage
  import dsp_in_pkg::*;
#(
  parameter int A_W         = 30,
  parameter int B_W         = 18,
  parameter int D_W         = 25,
  parameter int CAS_A_DEPTH = 1,
  parameter int CAS_B_DEPTH = 2,
  localparam int P_W = D_W + B_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  logic [D_W-1:0] d_in,
  input  logic           ce_a1,
  input  logic           ce_a2,
  input  logic           ce_b1,
  input  logic           ce_b2,
  input  logic           ce_d,
  input  logic           ce_m,
  input  logic [4:0]     mode,
  output logic [P_W-1:0] prod_out,
  output logic [A_W-1:0] acas_out,
  output logic [B_W-1:0] bcas_out
);

  mode_t          md;
  logic [A_W-1:0] a1_q, a2_q;
  logic [B_W-1:0] b1_q, b2_q;
  logic [D_W-1:0] d_q;
  logic [D_W-1:0] a_term, d_term, pre_sum;
  logic [B_W-1:0] mplier;

  assign md = mode_t'(mode);

  twin_reg_path #(.W(A_W), .CAS_DEPTH(CAS_A_DEPTH)) u_apath (
    .clk(clk), .rst(rst), .din(a_in), .ce1(ce_a1), .ce2(ce_a2),
    .q1(a1_q), .q2(a2_q), .cas_out(acas_out)
  );

  twin_reg_path #(.W(B_W), .CAS_DEPTH(CAS_B_DEPTH)) u_bpath (
    .clk(clk), .rst(rst), .din(b_in), .ce1(ce_b1), .ce2(ce_b2),
    .q1(b1_q), .q2(b2_q), .cas_out(bcas_out)
  );

  always_ff @(posedge clk) begin
    if (rst)       d_q <= '0;
    else if (ce_d) d_q <= d_in;
  end

  preadd_unit #(.D_W(D_W)) u_pre (
    .a_lvl1(a1_q[D_W-1:0]), .a_lvl2(a2_q[D_W-1:0]), .d_val(d_q), .md(md),
    .a_term(a_term), .d_term(d_term), .pre_sum(pre_sum)
  );

  mult_stage #(.D_W(D_W), .B_W(B_W)) u_mul (
    .clk(clk), .rst(rst), .ce_m(ce_m), .mcand(pre_sum),
    .b_lvl1(b1_q), .b_lvl2(b2_q), .b_first(md.b_first),
    .mplier(mplier), .m_q(prod_out)
  );

endmodule

// File: rtl/preadd_mult_stage_chk.sv
module preadd_mult_stage_chk #(
  parameter int A_W         = 30,
  parameter int B_W         = 18,
  parameter int D_W         = 25,
  parameter int CAS_A_DEPTH = 1,
  localparam int P_W = D_W + B_W
) (
  input logic           clk,
  input logic           rst,
  input logic [A_W-1:0] a_in,
  input logic [D_W-1:0] d_in,
  input logic           ce_a1,
  input logic           ce_a2,
  input logic           ce_d,
  input logic           ce_m,
  input logic [4:0]     mode,
  input logic [A_W-1:0] a1_q,
  input logic [A_W-1:0] a2_q,
  input logic [D_W-1:0] d_q,
  input logic [D_W-1:0] a_term,
  input logic [D_W-1:0] d_term,
  input logic [P_W-1:0] prod_out,
  input logic [A_W-1:0] acas_out,
  input logic [B_W-1:0] mplier
);

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> prod_out == '0);

  // R2
  a1_load_chk: assert property (@(posedge clk) disable iff (rst)
    ce_a1 |=> a1_q == $past(a_in));

  // R2
  a1_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ce_a1 |=> $stable(a1_q));

  // R2
  a2_load_chk: assert property (@(posedge clk) disable iff (rst)
    ce_a2 |=> a2_q == $past(a1_q));

  // R11
  d_load_chk: assert property (@(posedge clk) disable iff (rst)
    ce_d |=> d_q == $past(d_in));

  // R9
  m_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ce_m |=> $stable(prod_out));

  // R5
  zero_both_chk: assert property (@(posedge clk) disable iff (rst)
    (ce_m && mode[1] && !mode[2]) |=> prod_out == '0);

  // R5
  a_gate_chk: assert property (@(posedge clk) disable iff (rst)
    mode[1] |-> a_term == '0);

  // R6
  d_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !mode[2] |-> d_term == '0);

  // R9
  zero_mplier_chk: assert property (@(posedge clk) disable iff (rst)
    (ce_m && mplier == '0) |=> prod_out == '0);

  // R10
  generate
    if (CAS_A_DEPTH == 1) begin : g_cas1
      cas_a_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ce_a1 |=> $stable(acas_out));
    end else if (CAS_A_DEPTH == 2) begin : g_cas2
      cas_a_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ce_a2 |=> $stable(acas_out));
    end
  endgenerate

endmodule

bind preadd_mult_stage preadd_mult_stage_chk #(
  .A_W(A_W), .B_W(B_W), .D_W(D_W), .CAS_A_DEPTH(CAS_A_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .d_in(d_in), .ce_a1(ce_a1),
  .ce_a2(ce_a2), .ce_d(ce_d), .ce_m(ce_m), .mode(mode), .a1_q(a1_q),
  .a2_q(a2_q), .d_q(d_q), .a_term(a_term), .d_term(d_term),
  .prod_out(prod_out), .acas_out(acas_out), .mplier(mplier)
);

// File: tb/test_preadd_mult_stage.sv
module test_preadd_mult_stage;

  localparam int A_W = 30, B_W = 18, D_W = 25, CA = 1, CB = 2;
  localparam int P_W = D_W + B_W;

  logic clk = 1'b0;
  logic rst;
  logic [A_W-1:0] a_in;
  logic [B_W-1:0] b_in;
  logic [D_W-1:0] d_in;
  logic ce_a1, ce_a2, ce_b1, ce_b2, ce_d, ce_m;
  logic [4:0] mode;
  logic [P_W-1:0] prod_out;
  logic [A_W-1:0] acas_out;
  logic [B_W-1:0] bcas_out;

  always #10 clk = ~clk;  // 50 MHz

  preadd_mult_stage #(.A_W(A_W), .B_W(B_W), .D_W(D_W),
                      .CAS_A_DEPTH(CA), .CAS_B_DEPTH(CB)) i_preadd_mult_stage (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .d_in(d_in),
    .ce_a1(ce_a1), .ce_a2(ce_a2), .ce_b1(ce_b1), .ce_b2(ce_b2),
    .ce_d(ce_d), .ce_m(ce_m), .mode(mode), .prod_out(prod_out),
    .acas_out(acas_out), .bcas_out(bcas_out)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string cur_tag = "R1";

  // reference state
  logic [A_W-1:0] m_a1 = '0, m_a2 = '0;
  logic [B_W-1:0] m_b1 = '0, m_b2 = '0;
  logic [D_W-1:0] m_d = '0;
  longint m_p = 0;

  function automatic longint ref_prod(input logic [A_W-1:0] a1, input logic [A_W-1:0] a2,
                                      input logic [B_W-1:0] b1, input logic [B_W-1:0] b2,
                                      input logic [D_W-1:0] d, input logic [4:0] md);
    logic [24:0] al;
    longint av, dv, bv, s;
    al = md[0] ? a1[24:0] : a2[24:0];
    av = md[1] ? 64'sd0 : longint'($signed(al));
    dv = md[2] ? longint'($signed(d)) : 64'sd0;
    s  = md[3] ? dv - av : dv + av;
    s  = s & 64'sh1FFFFFF;
    if (s >= 64'sh1000000) s = s - 64'sh2000000;
    bv = md[4] ? longint'($signed(b1)) : longint'($signed(b2));
    return s * bv;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // apply current inputs for one edge, then compare at the falling edge
  task automatic tick();
    if (rst) begin
      m_a1 = '0; m_a2 = '0; m_b1 = '0; m_b2 = '0; m_d = '0; m_p = 0;
    end else begin
      if (ce_m)  m_p  = ref_prod(m_a1, m_a2, m_b1, m_b2, m_d, mode);
      if (ce_a2) m_a2 = m_a1;
      if (ce_a1) m_a1 = a_in;
      if (ce_b2) m_b2 = m_b1;
      if (ce_b1) m_b1 = b_in;
      if (ce_d)  m_d  = d_in;
    end
    @(negedge clk);
    check(cur_tag, longint'($signed(prod_out)), m_p);
    check("R10 acas", longint'(acas_out), longint'(CA == 0 ? a_in : (CA == 1 ? m_a1 : m_a2)));
    check("R10 bcas", longint'(bcas_out), longint'(CB == 0 ? b_in : (CB == 1 ? m_b1 : m_b2)));
  endtask

  task automatic idle_ces();
    ce_a1 = 0; ce_a2 = 0; ce_b1 = 0; ce_b2 = 0; ce_d = 0; ce_m = 0;
  endtask

  task automatic run_mode(input string tag, input logic [4:0] md, input longint exp);
    cur_tag = tag; idle_ces(); ce_m = 1; mode = md;
    tick();
    check(tag, longint'($signed(prod_out)), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    // R1: reset with enables and data active
    rst = 1; a_in = '1; b_in = '1; d_in = '1; mode = 5'h1F;
    ce_a1 = 1; ce_a2 = 1; ce_b1 = 1; ce_b2 = 1; ce_d = 1; ce_m = 1;
    cur_tag = "R1";
    tick();
    check("R1 prod", longint'(prod_out), 0);
    check("R1 acas", longint'(acas_out), 0);
    check("R1 bcas", longint'(bcas_out), 0);
    tick();
    rst = 0; idle_ces();

    // R2: fill the two levels with different values
    cur_tag = "R2";
    a_in = 100; ce_a1 = 1; b_in = 3; ce_b1 = 1; d_in = 1000; ce_d = 1;
    tick();
    idle_ces(); ce_a2 = 1; ce_b2 = 1; b_in = 5; ce_b1 = 1;
    tick();
    idle_ces(); a_in = 7; ce_a1 = 1;
    tick();
    check("R2 a1 level", longint'(acas_out), 7);
    check("R2 b2 level", longint'(bcas_out), 3);

    run_mode("R3", 5'b10001, 35);
    run_mode("R3", 5'b10000, 500);
    run_mode("R4", 5'b00001, 21);
    run_mode("R6", 5'b00101, 3021);
    run_mode("R7", 5'b01101, 2979);
    run_mode("R5", 5'b00111, 3000);
    run_mode("R5", 5'b00011, 0);

    // R9 hold and R11 D hold
    cur_tag = "R9"; idle_ces(); mode = 5'b10001; d_in = 55;
    tick();
    check("R9 hold", longint'($signed(prod_out)), 0);
    run_mode("R11", 5'b00101, 3021);

    // R7 wrap cases (B1 = 5)
    cur_tag = "R7"; idle_ces(); a_in = 1; ce_a1 = 1; d_in = 25'h0FFFFFF; ce_d = 1;
    tick();
    run_mode("R7", 5'b10101, -83886080);
    run_mode("R7", 5'b11001, -5);
    cur_tag = "R7"; idle_ces(); d_in = 25'h1000000; ce_d = 1;
    tick();
    run_mode("R7", 5'b11101, 83886075);

    // R8 upper A bits ignored
    cur_tag = "R8"; idle_ces(); a_in = 30'h3E000009; ce_a1 = 1;
    tick();
    run_mode("R8", 5'b10001, 45);

    // R10 cascades hold with enables low and ignore mode
    cur_tag = "R10"; idle_ces(); a_in = 30'h155; b_in = 18'h2A; mode = 5'b01010;
    tick();
    check("R10 acas", longint'(acas_out), 30'h3E000009);
    check("R10 bcas", longint'(bcas_out), 3);

    // R9 random mix
    cur_tag = "R9";
    for (int i = 0; i < 3000; i++) begin
      rst   = ($urandom_range(0, 99) == 0);
      a_in  = A_W'($urandom);
      b_in  = B_W'($urandom);
      d_in  = ($urandom_range(0, 7) == 0) ? 25'h0FFFFFF : D_W'($urandom);
      ce_a1 = 1'($urandom); ce_a2 = 1'($urandom);
      ce_b1 = 1'($urandom); ce_b2 = 1'($urandom);
      ce_d  = 1'($urandom); ce_m  = 1'($urandom);
      mode  = 5'($urandom);
      tick();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule